// File: doc/BRIEF.md
# Register-Parity Cluster Distribution Unit

This unit sits between instruction fetch and the two execution clusters of a partitioned, dynamically scheduled core. For every fetched instruction it looks at the architectural register numbers the instruction names: two optional sources and one optional destination. It also looks at a mask that marks some registers as global, meaning they are present in both clusters. Every other register is local: even numbers live in cluster 0 and odd numbers in cluster 1. From this the unit decides whether the instruction runs in one cluster, or is split into a master copy that computes and a slave copy in the other cluster. It also decides which copies claim a new physical destination register, and whether the slave forwards a source operand, receives the computed result, or does both.

Instructions are handled strictly in fetch order. Each cluster reports whether it has a free dispatch-queue entry and a free physical register. When any cluster the instruction needs cannot supply what it needs, the unit raises a stall and dispatches nothing, so a split instruction never lands in only one cluster. An accepted instruction appears on the registered dispatch outputs on the following clock edge.

Top module: `cdu_dist_unit`

## Requirements
- R1: When no destination is global and every named local register lies in one cluster, the instruction is dispatched to that cluster only: `disp_vld_o` is one-hot and `master_o` equals it. Bit 0 means cluster 0.
- R2: Register n is global when `glob_mask_i[n]` is 1. A global source never affects routing. A local register n belongs to cluster n[0].
- R3: An instruction that names no local register and no destination goes to cluster 0 alone, with no allocation.
- R4: The instruction is dual-dispatched (`disp_vld_o` = 2'b11) when the destination is global or when named local registers lie in both clusters. The master is the cluster holding more of the named local registers. On a tie it is the cluster of the first local source (src0 before src1). With no local register at all it is the destination's parity. `master_o` is one-hot.
- R5: `opnd_fwd_o` is 1 exactly when the instruction is dual and a local source lies in the slave cluster.
- R6: A copy gets `dst_alloc_o` set when a destination is named and it is either global or local to that copy's cluster. `rslt_fwd_o` is 1 exactly when the destination is global, or local to the slave cluster.
- R7: `stall_o` is 1 when `inst_vld_i` is 1 and a target cluster lacks a queue entry (`q_avail_i`), or lacks a physical register (`preg_avail_i`) for a copy that allocates. Clusters that are not targeted are not consulted. On a stall neither copy is dispatched.
- R8: The dispatch outputs show an instruction one cycle after the cycle it is accepted, and they are all zero after any cycle without an acceptance.
- R9: After reset all dispatch outputs are zero.
- R10: An instruction without a destination sets no `dst_alloc_o` bit and no `rslt_fwd_o`, and needs no physical register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_vld_i | input | 1 | Instruction present this cycle |
| src0_vld_i | input | 1 | First source is named |
| src0_i | input | AW | First source register number |
| src1_vld_i | input | 1 | Second source is named |
| src1_i | input | AW | Second source register number |
| dst_vld_i | input | 1 | Destination is named |
| dst_i | input | AW | Destination register number |
| glob_mask_i | input | NUM_AREGS | 1 marks a register as global |
| q_avail_i | input | 2 | Per-cluster dispatch-queue entry free |
| preg_avail_i | input | 2 | Per-cluster physical register free |
| stall_o | output | 1 | Instruction held this cycle |
| disp_vld_o | output | 2 | Per-cluster dispatch valid (registered) |
| master_o | output | 2 | Per-cluster master-copy marker |
| dst_alloc_o | output | 2 | Per-cluster destination allocation |
| opnd_fwd_o | output | 1 | Slave forwards a source operand to the master |
| rslt_fwd_o | output | 1 | Master forwards its result to the slave |

## Verification
Directed instructions cover each routing shape:
- all-local single-cluster cases on each parity;
- global sources mixed with local ones;
- split sources with a local destination;
- same-cluster sources with a destination in the other cluster;
- a global destination with sources in one cluster, and with sources split;
- a global-only instruction.

Together these separate the majority rule from the tie-breaks and the operand path from the result path. Resource patterns that starve only the slave, only a non-targeted cluster, or only the physical registers of an instruction without a destination show whether the stall is all-or-nothing and limited to the clusters actually targeted. A long run of pseudo-random instructions and resource vectors is then compared against the reference model every cycle.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  localparam int unsigned NUM_CL = 2;

  typedef struct packed {
    logic [NUM_CL-1:0] disp;
    logic [NUM_CL-1:0] master;
    logic [NUM_CL-1:0] alloc;
    logic              opnd_fwd;
    logic              rslt_fwd;
  } route_t;

  localparam int unsigned SRC0 = 0;
  localparam int unsigned SRC1 = 1;
  localparam int unsigned DST  = 2;
  localparam int unsigned NUM_FIELDS = 3;
endpackage

// File: rtl/cdu_reg_classify.sv
module cdu_reg_classify #(
  parameter int unsigned NUM_AREGS = 32,
  localparam int unsigned AW = $clog2(NUM_AREGS)
) (
  input  logic                 vld_i,
  input  logic [AW-1:0]        num_i,
  input  logic [NUM_AREGS-1:0] glob_mask_i,
  output logic                 local_o,
  output logic                 glob_o,
  output logic                 cl_o
);
  logic is_glob;

  assign is_glob = glob_mask_i[num_i];
  assign glob_o  = vld_i & is_glob;
  assign local_o = vld_i & ~is_glob;
  assign cl_o    = num_i[0];
endmodule

// File: rtl/cdu_route.sv
module cdu_route
  import cdu_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] vld_i,
  input  logic [NUM_FIELDS-1:0] local_i,
  input  logic [NUM_FIELDS-1:0] glob_i,
  input  logic [NUM_FIELDS-1:0] cl_i,
  output route_t                route_o
);
  localparam int unsigned CW = $clog2(NUM_FIELDS + 1);

  logic [CW-1:0]     cnt [NUM_CL];
  logic [NUM_CL-1:0] src_in;
  logic              dual, mst, slv, tie_cl, single_cl;

  always_comb begin
    for (int c = 0; c < NUM_CL; c++) cnt[c] = '0;
    src_in = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (local_i[f]) cnt[cl_i[f]] = cnt[cl_i[f]] + CW'(1);
    end
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (f != DST && local_i[f]) src_in[cl_i[f]] = 1'b1;
    end
  end

  // tie-break: first local source, otherwise destination parity
  always_comb begin
    if (local_i[SRC0])      tie_cl = cl_i[SRC0];
    else if (local_i[SRC1]) tie_cl = cl_i[SRC1];
    else                    tie_cl = cl_i[DST];
  end

  assign dual      = glob_i[DST] | ((cnt[0] != '0) & (cnt[1] != '0));
  assign single_cl = (cnt[1] != '0);

  always_comb begin
    if (cnt[0] > cnt[1])      mst = 1'b0;
    else if (cnt[1] > cnt[0]) mst = 1'b1;
    else                      mst = tie_cl;
  end
  assign slv = ~mst;

  always_comb begin
    route_o = '0;
    if (!dual) begin
      route_o.disp[single_cl]   = 1'b1;
      route_o.master[single_cl] = 1'b1;
      route_o.alloc[single_cl]  = vld_i[DST];
    end else begin
      route_o.disp   = '1;
      route_o.master[mst] = 1'b1;
      if (glob_i[DST])       route_o.alloc = '1;
      else if (local_i[DST]) route_o.alloc[cl_i[DST]] = 1'b1;
      route_o.opnd_fwd = src_in[slv];
      route_o.rslt_fwd = glob_i[DST] | (local_i[DST] & (cl_i[DST] == slv));
    end
  end
endmodule

// File: rtl/cdu_resource_gate.sv
module cdu_resource_gate
  import cdu_pkg::*;
(
  input  logic [NUM_CL-1:0] disp_i,
  input  logic [NUM_CL-1:0] alloc_i,
  input  logic [NUM_CL-1:0] q_avail_i,
  input  logic [NUM_CL-1:0] preg_avail_i,
  output logic              ok_o
);
  logic [NUM_CL-1:0] cl_ok;

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    assign cl_ok[c] = (~disp_i[c]  | q_avail_i[c]) &
                      (~alloc_i[c] | preg_avail_i[c]);
  end

  assign ok_o = &cl_ok;
endmodule

// File: rtl/cdu_dist_unit.sv
module cdu_dist_unit
  import cdu_pkg::*;
#(
  parameter int unsigned NUM_AREGS = 32,
  localparam int unsigned AW = $clog2(NUM_AREGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inst_vld_i,
  input  logic                 src0_vld_i,
  input  logic [AW-1:0]        src0_i,
  input  logic                 src1_vld_i,
  input  logic [AW-1:0]        src1_i,
  input  logic                 dst_vld_i,
  input  logic [AW-1:0]        dst_i,
  input  logic [NUM_AREGS-1:0] glob_mask_i,
  input  logic [1:0]           q_avail_i,
  input  logic [1:0]           preg_avail_i,
  output logic                 stall_o,
  output logic [1:0]           disp_vld_o,
  output logic [1:0]           master_o,
  output logic [1:0]           dst_alloc_o,
  output logic                 opnd_fwd_o,
  output logic                 rslt_fwd_o
);
  logic [NUM_FIELDS-1:0] f_vld, f_local, f_glob, f_cl;
  logic [AW-1:0]         f_num [NUM_FIELDS];
  route_t                route, route_q;
  logic                  res_ok, accept;

  assign f_vld[SRC0] = src0_vld_i;
  assign f_vld[SRC1] = src1_vld_i;
  assign f_vld[DST]  = dst_vld_i;
  assign f_num[SRC0] = src0_i;
  assign f_num[SRC1] = src1_i;
  assign f_num[DST]  = dst_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cls
    cdu_reg_classify #(.NUM_AREGS(NUM_AREGS)) u_cls (
      .vld_i       (f_vld[f]),
      .num_i       (f_num[f]),
      .glob_mask_i (glob_mask_i),
      .local_o     (f_local[f]),
      .glob_o      (f_glob[f]),
      .cl_o        (f_cl[f])
    );
  end

  cdu_route u_route (
    .vld_i   (f_vld),
    .local_i (f_local),
    .glob_i  (f_glob),
    .cl_i    (f_cl),
    .route_o (route)
  );

  cdu_resource_gate u_gate (
    .disp_i       (route.disp),
    .alloc_i      (route.alloc),
    .q_avail_i    (q_avail_i),
    .preg_avail_i (preg_avail_i),
    .ok_o         (res_ok)
  );

  assign accept  = inst_vld_i & res_ok;
  assign stall_o = inst_vld_i & ~res_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     route_q <= '0;
    else if (accept) route_q <= route;
    else             route_q <= '0;
  end

  assign disp_vld_o  = route_q.disp;
  assign master_o    = route_q.master;
  assign dst_alloc_o = route_q.alloc;
  assign opnd_fwd_o  = route_q.opnd_fwd;
  assign rslt_fwd_o  = route_q.rslt_fwd;
endmodule

// File: rtl/cdu_dist_chk.sv
module cdu_dist_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inst_vld_i,
  input logic       stall_o,
  input logic [1:0] q_avail_i,
  input logic [1:0] preg_avail_i,
  input logic [1:0] disp_vld_o,
  input logic [1:0] master_o,
  input logic [1:0] dst_alloc_o,
  input logic       opnd_fwd_o,
  input logic       rslt_fwd_o
);
  assert_stall_needs_inst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> inst_vld_i);

  assert_idle_after_no_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inst_vld_i && !stall_o) |=> (disp_vld_o == 2'b00));

  assert_disp_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_vld_i && !stall_o) |=> (disp_vld_o != 2'b00));

  assert_queue_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_vld_o != 2'b00) |-> ((disp_vld_o & ~$past(q_avail_i)) == 2'b00));

  assert_preg_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_alloc_o != 2'b00) |-> ((dst_alloc_o & ~$past(preg_avail_i)) == 2'b00));

  assert_alloc_in_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_alloc_o & ~disp_vld_o) == 2'b00);

  assert_fwd_only_dual_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_fwd_o || rslt_fwd_o) |-> (disp_vld_o == 2'b11));

  assert_one_master_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_vld_o != 2'b00) |-> ($countones(master_o) == 1 && (master_o & ~disp_vld_o) == 2'b00));
endmodule

bind cdu_dist_unit cdu_dist_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inst_vld_i   (inst_vld_i),
  .stall_o      (stall_o),
  .q_avail_i    (q_avail_i),
  .preg_avail_i (preg_avail_i),
  .disp_vld_o   (disp_vld_o),
  .master_o     (master_o),
  .dst_alloc_o  (dst_alloc_o),
  .opnd_fwd_o   (opnd_fwd_o),
  .rslt_fwd_o   (rslt_fwd_o)
);

// File: tb/test_cdu_dist_unit.sv
`timescale 1ns/1ps
module test_cdu_dist_unit;
  localparam int NA = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inst_vld = 1'b0, s0v = 1'b0, s1v = 1'b0, dv = 1'b0;
  logic [AW-1:0] s0 = '0, s1 = '0, d = '0;
  logic [NA-1:0] gmask = 32'h6000_0000;
  logic [1:0]    qa = 2'b11, pa = 2'b11;
  logic          stall;
  logic [1:0]    disp, mst, alloc;
  logic          opf, rsf;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q = '0;
  string      exp_tag = "R9";

  always #2.5 clk = ~clk;

  cdu_dist_unit #(.NUM_AREGS(NA)) i_cdu_dist_unit (
    .clk_i(clk), .rst_ni(rst_n), .inst_vld_i(inst_vld),
    .src0_vld_i(s0v), .src0_i(s0), .src1_vld_i(s1v), .src1_i(s1),
    .dst_vld_i(dv), .dst_i(d), .glob_mask_i(gmask),
    .q_avail_i(qa), .preg_avail_i(pa), .stall_o(stall),
    .disp_vld_o(disp), .master_o(mst), .dst_alloc_o(alloc),
    .opnd_fwd_o(opf), .rslt_fwd_o(rsf)
  );

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  // Reference: {disp[1:0], master[1:0], alloc[1:0], opnd, rslt}
  function automatic logic [7:0] model(input logic a0v, input int a0, input logic a1v,
                                       input int a1, input logic adv, input int ad,
                                       input logic [NA-1:0] gm);
    int cnt[2];
    bit in_src[2];
    int first, m, s;
    bit dglob, dual;
    logic [1:0] dp, ms, al;
    bit op, rs;
    cnt = '{0, 0}; in_src = '{0, 0}; first = -1;
    if (a0v && !gm[a0]) begin cnt[a0 % 2]++; in_src[a0 % 2] = 1; first = a0 % 2; end
    if (a1v && !gm[a1]) begin cnt[a1 % 2]++; in_src[a1 % 2] = 1; if (first < 0) first = a1 % 2; end
    dglob = adv && gm[ad];
    if (adv && !dglob) cnt[ad % 2]++;
    dual = dglob || (cnt[0] > 0 && cnt[1] > 0);
    op = 0; rs = 0;
    if (!dual) begin
      m = (cnt[1] > 0) ? 1 : 0;
      dp = 2'(1 << m); ms = dp; al = adv ? dp : 2'b00;
    end else begin
      if (cnt[0] > cnt[1]) m = 0;
      else if (cnt[1] > cnt[0]) m = 1;
      else if (first >= 0) m = first;
      else m = ad % 2;
      s = 1 - m;
      dp = 2'b11; ms = 2'(1 << m);
      al = !adv ? 2'b00 : dglob ? 2'b11 : 2'(1 << (ad % 2));
      op = in_src[s];
      rs = dglob || (adv && (ad % 2) == s);
    end
    return {dp, ms, al, op, rs};
  endfunction

  task automatic check_outputs();
    string t;
    t = (exp_q == 8'h00 && exp_tag != "R9") ? "R8" : exp_tag;
    chk(t, "disp(R1)", disp, exp_q[7:6]);
    chk(t, "master(R4)", mst, exp_q[5:4]);
    chk(t, "alloc(R6)", alloc, exp_q[3:2]);
    chk(t, "opnd_fwd(R5)", opf, exp_q[1]);
    chk(t, "rslt_fwd(R6)", rsf, exp_q[0]);
  endtask

  task automatic step(input string tag, input logic v, input logic a0v, input int a0,
                      input logic a1v, input int a1, input logic adv, input int ad,
                      input logic [1:0] q, input logic [1:0] p);
    logic [7:0] r;
    bit ok;
    @(negedge clk);
    check_outputs();
    inst_vld = v; s0v = a0v; s0 = AW'(a0); s1v = a1v; s1 = AW'(a1);
    dv = adv; d = AW'(ad); qa = q; pa = p;
    #1;
    r  = model(a0v, a0, a1v, a1, adv, ad, gmask);
    ok = ((r[7:6] & ~q) == 2'b00) && ((r[3:2] & ~p) == 2'b00);
    chk(tag, "stall(R7)", stall, int'(v && !ok));
    exp_q   = (v && ok) ? r : 8'h00;
    exp_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outputs();                       // R9 reset state
    rst_n = 1'b1;
    // R1 single cluster, both parities
    step("R1", 1, 1, 2, 1, 4, 1, 6, 2'b11, 2'b11);
    step("R1", 1, 1, 3, 1, 5, 1, 7, 2'b11, 2'b11);
    // R2 global sources ignored, parity mapping
    step("R2", 1, 1, 30, 1, 4, 1, 8, 2'b11, 2'b11);
    step("R2", 1, 1, 29, 0, 0, 1, 9, 2'b11, 2'b11);
    // R3 nothing local, no destination
    step("R3", 1, 0, 0, 0, 0, 0, 0, 2'b11, 2'b11);
    step("R3", 1, 1, 30, 1, 29, 0, 0, 2'b11, 2'b11);
    // R4/R5 split sources, majority in cluster 1
    step("R4", 1, 1, 2, 1, 3, 1, 5, 2'b11, 2'b11);
    // R6 result forward to other cluster, global destination
    step("R6", 1, 1, 2, 1, 4, 1, 7, 2'b11, 2'b11);
    step("R6", 1, 1, 2, 1, 4, 1, 30, 2'b11, 2'b11);
    // R4 tie: operand and result both forwarded
    step("R4", 1, 1, 3, 1, 2, 1, 30, 2'b11, 2'b11);
    // R10 split, no destination
    step("R10", 1, 1, 2, 1, 3, 0, 0, 2'b11, 2'b11);
    // R4 global-only, master by destination parity
    step("R4", 1, 1, 30, 0, 0, 1, 29, 2'b11, 2'b11);
    // R7 stall cases: missing queue, missing slave preg, non-target starved
    step("R7", 1, 1, 2, 1, 4, 1, 7, 2'b01, 2'b11);
    step("R7", 1, 1, 2, 1, 4, 1, 7, 2'b11, 2'b01);
    step("R7", 1, 1, 2, 1, 4, 1, 6, 2'b01, 2'b01);
    step("R10", 1, 1, 2, 1, 4, 0, 0, 2'b01, 2'b00);
    step("R8", 0, 1, 2, 1, 4, 1, 6, 2'b11, 2'b11);
    // pseudo-random stream
    void'($urandom(32'd11));
    for (int i = 0; i < 400; i++) begin
      step("R4", ($urandom % 4) != 0, $urandom % 2, $urandom % NA, $urandom % 2,
           $urandom % NA, $urandom % 2, $urandom % NA, 2'($urandom), 2'($urandom));
    end
    step("R8", 0, 0, 0, 0, 0, 0, 0, 2'b11, 2'b11);
    @(negedge clk);
    check_outputs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule